// File: doc/BRIEF.md
# Display Interrupt Collector

This block gathers the four event sources of a display controller into one small register-mapped interrupt unit. Three sources arrive as single-cycle pulses from neighbouring logic: pixel FIFO underflow, acceptance of a new frame base address, and a bus error seen by the fetch engine. The fourth, the vertical compare event, is produced inside the block by watching the controller's current vertical phase and firing when the frame enters a phase chosen by software.

Each source owns a sticky status bit, set by its event whatever the enable says. Software enables sources, reads status and clears it by writing ones. Every source drives its own interrupt line, and one combined line is high while any enabled source is pending. The host port is a plain 32-bit single-cycle read/write port with a byte address; read data is a combinational function of the address and current state.

Top module: `dispirq_unit`

## Requirements
- R1: Status is read at byte offset 0x10 with bit 0 = FIFO underflow, bit 1 = frame base update, bit 2 = vertical compare, bit 3 = bus error; an event pulse sets its bit on the next clock edge whatever its enable, and the bit stays set until cleared.
- R2: The enable register at offset 0x08 holds one enable per source at the same bit positions as status, is written by a write to that offset and reads back bits [3:0] with upper bits zero.
- R3: A write to offset 0x0C clears each status bit whose data bit is one and leaves the others; writing 0x0F clears all four. Offset 0x0C reads as zero.
- R4: When an event pulse and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R5: Each interrupt line irq_line[i] equals status bit i AND enable bit i, with no added cycle of delay.
- R6: irq_any is high exactly when at least one irq_line bit is high.
- R7: The compare select register at offset 0x04 holds a 2-bit field in bits [1:0], read back with upper bits zero; value and vphase share the encoding 0 = vertical sync, 1 = back porch, 2 = active image, 3 = front porch.
- R8: The vertical compare event fires for one cycle when vphase changes into the selected phase; staying in that phase, or the select being changed to the phase already present, does not fire it, and it never fires in the first cycle after reset.
- R9: Reset (rst_n low at a clock edge) clears enable, status and compare select to zero.
- R10: Writes to the status offset or to any unmapped offset change no state, and reads of unmapped offsets return zero; the full address is decoded, so 0x48 is not an alias of 0x08.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | ADDR_W | Byte address of the register access |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| ev_underflow | input | 1 | FIFO underflow event pulse |
| ev_base_upd | input | 1 | Frame base address taken event pulse |
| ev_bus_err | input | 1 | Bus error event pulse |
| vphase | input | 2 | Current vertical phase, encoded as in R7 |
| irq_line | output | 4 | Per-source interrupt lines |
| irq_any | output | 1 | Combined interrupt line |

## Verification
The bench builds the unit with ADDR_W = 8, so the four mapped offsets sit among unmapped addresses such as 0x48 that share their low bits; this makes a partial address decode visible as an alias. With the 2-bit select at its natural width, all four compare phases are walked through complete frames, and the select is also moved onto the phase that is currently present to show no false entry. Same-cycle clear and set collisions are driven on purpose to expose the priority between them.

// File: rtl/dispirq_pkg.sv
// Shared constants for the display interrupt collector.
// Assumes byte addressing of 32-bit registers.
package dispirq_pkg;
    localparam int NSRC    = 4;
    localparam int DATA_W  = 32;
    localparam int SEL_W   = 2;

    // Source bit positions, decoded by software.
    localparam int SRC_UFLOW = 0;
    localparam int SRC_BASE  = 1;
    localparam int SRC_VCMP  = 2;
    localparam int SRC_BERR  = 3;

    // Register byte offsets.
    localparam int OFS_SEL  = 'h04;
    localparam int OFS_EN   = 'h08;
    localparam int OFS_CLR  = 'h0C;
    localparam int OFS_STAT = 'h10;

    typedef enum logic [SEL_W-1:0] {
        PH_SYNC   = 2'd0,
        PH_BPORCH = 2'd1,
        PH_ACTIVE = 2'd2,
        PH_FPORCH = 2'd3
    } vphase_e;
endpackage

// File: rtl/dispirq_vcmp.sv
// Vertical compare detector: pulses for one cycle when the incoming
// vertical phase changes into the selected phase.
// Assumes vphase is synchronous to clk and changes at most once per cycle.
module dispirq_vcmp #(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] vphase,
    input  logic [SEL_W-1:0] sel,
    output logic             hit
);
    logic [SEL_W-1:0] prev_q;
    logic             valid_q;

    // Remember the phase seen in the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            prev_q  <= vphase;
            valid_q <= 1'b1;
        end
    end

    // Fire on entry into the selected phase only.
    always_comb begin
        hit = valid_q && (vphase == sel) && (vphase != prev_q);
    end
endmodule

// File: rtl/dispirq_status.sv
// Sticky status bank: one bit per source, set by events, cleared by a
// mask; a set in the same cycle as a clear wins.
// Assumes set and clr are single-cycle qualified strobes.
module dispirq_status #(
    parameter int NSRC = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] set,
    input  logic [NSRC-1:0] clr,
    output logic [NSRC-1:0] stat
);
    for (genvar i = 0; i < NSRC; i++) begin : g_bit
        logic bit_q;

        // Hold the pending flag for source i.
        always_ff @(posedge clk) begin
            if (!rst_n)
                bit_q <= 1'b0;
            else if (set[i])
                bit_q <= 1'b1;
            else if (clr[i])
                bit_q <= 1'b0;
        end

        assign stat[i] = bit_q;
    end
endmodule

// File: rtl/dispirq_regs.sv
// Host register file: compare select, enable, clear strobe and read mux.
// Assumes one-cycle writes and a full decode of the byte address.
module dispirq_regs
    import dispirq_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [NSRC-1:0]   stat,
    output logic [NSRC-1:0]   en_q,
    output logic [SEL_W-1:0]  sel_q,
    output logic [NSRC-1:0]   clr,
    output logic [DATA_W-1:0] rdata
);
    localparam logic [ADDR_W-1:0] A_SEL  = ADDR_W'(OFS_SEL);
    localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(OFS_EN);
    localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(OFS_CLR);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);

    logic hit_sel, hit_en, hit_clr, hit_stat;

    // Decode the full address.
    always_comb begin
        hit_sel  = (addr == A_SEL);
        hit_en   = (addr == A_EN);
        hit_clr  = (addr == A_CLR);
        hit_stat = (addr == A_STAT);
    end

    // Writable enable and compare select state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= '0;
            sel_q <= '0;
        end else if (wr) begin
            if (hit_en)
                en_q <= wdata[NSRC-1:0];
            if (hit_sel)
                sel_q <= wdata[SEL_W-1:0];
        end
    end

    // Write-one-to-clear strobe for the status bank.
    always_comb begin
        clr = (wr && hit_clr) ? wdata[NSRC-1:0] : '0;
    end

    // Read multiplexer; unmapped offsets read zero.
    always_comb begin
        rdata = '0;
        if (hit_sel)
            rdata[SEL_W-1:0] = sel_q;
        else if (hit_en)
            rdata[NSRC-1:0] = en_q;
        else if (hit_stat)
            rdata[NSRC-1:0] = stat;
    end
endmodule

// File: rtl/dispirq_unit.sv
// Display interrupt collector top: joins event pulses and the vertical
// compare detector into sticky status, gates it with enables and drives
// per-source and combined interrupt lines.
// Assumes all inputs are synchronous to clk.
module dispirq_unit
    import dispirq_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              ev_underflow,
    input  logic              ev_base_upd,
    input  logic              ev_bus_err,
    input  logic [1:0]        vphase,
    output logic [3:0]        irq_line,
    output logic              irq_any
);
    logic [NSRC-1:0]  en_q;
    logic [NSRC-1:0]  stat_q;
    logic [NSRC-1:0]  clr;
    logic [NSRC-1:0]  set;
    logic [SEL_W-1:0] sel_q;
    logic             vcmp_ev;

    dispirq_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (reg_addr),
        .wr    (reg_wr),
        .wdata (reg_wdata),
        .stat  (stat_q),
        .en_q  (en_q),
        .sel_q (sel_q),
        .clr   (clr),
        .rdata (reg_rdata)
    );

    dispirq_vcmp #(.SEL_W(SEL_W)) u_vcmp (
        .clk    (clk),
        .rst_n  (rst_n),
        .vphase (vphase),
        .sel    (sel_q),
        .hit    (vcmp_ev)
    );

    // Place each event at its fixed status position.
    always_comb begin
        set            = '0;
        set[SRC_UFLOW] = ev_underflow;
        set[SRC_BASE]  = ev_base_upd;
        set[SRC_VCMP]  = vcmp_ev;
        set[SRC_BERR]  = ev_bus_err;
    end

    dispirq_status #(.NSRC(NSRC)) u_stat (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (set),
        .clr   (clr),
        .stat  (stat_q)
    );

    // Gate each pending source with its enable.
    for (genvar i = 0; i < NSRC; i++) begin : g_line
        assign irq_line[i] = stat_q[i] & en_q[i];
    end

    // Combined line: any enabled source pending.
    always_comb begin
        irq_any = |(stat_q & en_q);
    end
endmodule

// File: rtl/dispirq_unit_chk.sv
// Property checker for the display interrupt collector, bound to the top.
// Assumes the default register offsets from the package.
module dispirq_unit_chk
    import dispirq_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_wr,
    input logic [31:0]       reg_wdata,
    input logic              ev_underflow,
    input logic [1:0]        vphase,
    input logic [3:0]        irq_line,
    input logic              irq_any,
    input logic [3:0]        en_q,
    input logic [3:0]        stat_q,
    input logic [1:0]        sel_q,
    input logic              vcmp_ev
);
    AST_LINE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_line & ~en_q) == 4'b0000); // R5
    AST_ANY_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        irq_any == (irq_line != 4'b0000)); // R6
    AST_EVENT_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        ev_underflow |=> stat_q[SRC_UFLOW]); // R4
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_W'(OFS_CLR) && reg_wdata[SRC_UFLOW] && !ev_underflow)
        |=> !stat_q[SRC_UFLOW]); // R3
    AST_VCMP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        vcmp_ev |-> (vphase == sel_q) && (vphase != $past(vphase))); // R8
    AST_VCMP_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_q[SRC_VCMP]) |-> $past(vcmp_ev)); // R1
endmodule

bind dispirq_unit dispirq_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_addr     (reg_addr),
    .reg_wr       (reg_wr),
    .reg_wdata    (reg_wdata),
    .ev_underflow (ev_underflow),
    .vphase       (vphase),
    .irq_line     (irq_line),
    .irq_any      (irq_any),
    .en_q         (en_q),
    .stat_q       (stat_q),
    .sel_q        (sel_q),
    .vcmp_ev      (vcmp_ev)
);

// File: tb/dispirq_unit_tb.sv
`timescale 1ns/1ps
// Bench: behavioural reference model stepped alongside the unit,
// compared on every clock.
module dispirq_unit_tb;
    localparam int ADDR_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic              reg_wr = 1'b0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic              ev_underflow = 1'b0;
    logic              ev_base_upd = 1'b0;
    logic              ev_bus_err = 1'b0;
    logic [1:0]        vphase = 2'd0;
    logic [3:0]        irq_line;
    logic              irq_any;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    // Reference model state.
    int m_en = 0, m_stat = 0, m_sel = 0, m_prev = 0;
    bit m_valid = 1'b0;

    always #2 clk = ~clk;

    dispirq_unit #(.ADDR_W(ADDR_W)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_addr     (reg_addr),
        .reg_wr       (reg_wr),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .ev_underflow (ev_underflow),
        .ev_base_upd  (ev_base_upd),
        .ev_bus_err   (ev_bus_err),
        .vphase       (vphase),
        .irq_line     (irq_line),
        .irq_any      (irq_any)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int model_read(int a);
        case (a)
            'h04:    return m_sel;
            'h08:    return m_en;
            'h10:    return m_stat;
            default: return 0;
        endcase
    endfunction

    // One clock: drive at the falling edge, check read data, advance the
    // model at the rising edge, check interrupt lines at the next fall.
    task automatic step(string req, int a, bit wr, int wd, int ev, int ph);
        int setm, clrm, hit;
        reg_addr     = a[ADDR_W-1:0];
        reg_wr       = wr;
        reg_wdata    = wd;
        ev_underflow = ev[0];
        ev_base_upd  = ev[1];
        ev_bus_err   = ev[3];
        vphase       = ph[1:0];
        #1;
        chk({req, " rdata"}, reg_rdata, model_read(a));
        hit  = (m_valid && ph == m_sel && ph != m_prev) ? 1 : 0;
        setm = (ev & 'hB) | (hit << 2);
        clrm = (wr && a == 'h0C) ? (wd & 'hF) : 0;
        @(posedge clk);
        m_stat  = (m_stat & ~clrm) | setm;
        if (wr && a == 'h08) m_en  = wd & 'hF;
        if (wr && a == 'h04) m_sel = wd & 'h3;
        m_prev  = ph;
        m_valid = 1'b1;
        @(negedge clk);
        chk({req, " R5 irq_line"}, 32'(irq_line), m_stat & m_en);
        chk({req, " R6 irq_any"}, 32'(irq_any), ((m_stat & m_en) != 0) ? 1 : 0);
    endtask

    // Walk one frame, holding each phase for three cycles.
    task automatic frame(string req);
        for (int p = 0; p < 4; p++)
            for (int k = 0; k < 3; k++)
                step(req, 'h10, 0, 0, 0, p);
    endtask

    initial begin : watchdog
        #(200000 * 4);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin : stim
        vphase = 2'd2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_valid = 1'b0;
        // R9: reset state; phase already equals select 0? no: phase 2, check no spurious fire (R8)
        step("R9 sel", 'h04, 0, 0, 0, 2);
        step("R9 en", 'h08, 0, 0, 0, 2);
        step("R9 stat", 'h10, 0, 0, 0, 2);
        chk("R9 stat zero", reg_rdata, 0);

        // R1: event sets status with enable off
        step("R1 uflow", 'h10, 0, 0, 'h1, 2);
        step("R1 read", 'h10, 0, 0, 0, 2);
        chk("R1 stat bit0", reg_rdata, 32'h1);
        chk("R5 masked", 32'(irq_line), 0);

        // R2: enable write and readback
        step("R2 wr en", 'h08, 1, 'hFFFF_FFF1, 0, 2);
        step("R2 rd en", 'h08, 0, 0, 0, 2);
        chk("R2 en read", reg_rdata, 32'h1);
        chk("R6 any", 32'(irq_any), 1);

        step("R1 base+berr", 'h10, 0, 0, 'hA, 2);
        step("R1 read", 'h10, 0, 0, 0, 2);
        chk("R1 stat 0xB", reg_rdata, 32'hB);

        // R3: partial clear, then read of clear offset
        step("R3 clr bit1", 'h0C, 1, 'h2, 0, 2);
        step("R3 rd clr", 'h0C, 0, 0, 0, 2);
        step("R3 read", 'h10, 0, 0, 0, 2);
        chk("R3 stat 0x9", reg_rdata, 32'h9);

        // R4: clear collides with a set on bit 0
        step("R4 collide", 'h0C, 1, 'h1, 'h1, 2);
        step("R4 read", 'h10, 0, 0, 0, 2);
        chk("R4 set wins", reg_rdata, 32'h9);

        step("R3 clr all", 'h0C, 1, 'hF, 0, 2);
        step("R3 read", 'h10, 0, 0, 0, 2);
        chk("R3 all clear", reg_rdata, 0);

        // R10: ignored writes and unmapped reads
        step("R10 wr stat", 'h10, 1, 'hF, 0, 2);
        step("R10 wr alias", 'h48, 1, 'hF, 0, 2);
        step("R10 rd alias", 'h48, 0, 0, 0, 2);
        step("R10 rd en", 'h08, 0, 0, 0, 2);
        chk("R10 en kept", reg_rdata, 32'h1);
        step("R10 rd stat", 'h10, 0, 0, 0, 2);
        chk("R10 stat kept", reg_rdata, 0);

        // R7 / R8: each compare phase over a full frame
        step("R7 en all", 'h08, 1, 'hF, 0, 0);
        for (int s = 0; s < 4; s++) begin
            step("R7 wr sel", 'h04, 1, s, 0, 3);
            step("R7 rd sel", 'h04, 0, 0, 0, 3);
            chk("R7 sel read", reg_rdata, s);
            step("R3 clr", 'h0C, 1, 'hF, 0, 3);
            frame("R8 frame");
            chk("R8 fired once", 32'(irq_line), 32'h4);
        end

        // R8: select moved onto the current phase does not fire
        step("R3 clr", 'h0C, 1, 'hF, 0, 1);
        step("R8 sel here", 'h04, 1, 1, 0, 1);
        step("R8 hold", 'h10, 0, 0, 0, 1);
        step("R8 hold", 'h10, 0, 0, 0, 1);
        chk("R8 no fire", reg_rdata, 0);

        // R9: reset mid-run clears state
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_en = 0; m_stat = 0; m_sel = 0; m_valid = 1'b0;
        step("R9 after", 'h08, 0, 0, 0, 0);
        chk("R9 en clear", reg_rdata, 0);
        step("R9 after", 'h04, 0, 0, 0, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule